// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind a small byte-wide register window. Four word-aligned slots make up the window: one data slot per counter and one write-only command slot. Software writes a command byte to the command slot. The byte picks a counter and then either configures it, by giving a counting behaviour and a two-byte load sequence, or snapshots its current count. The count itself is then written or read through that counter's data slot as two bytes, low byte first.

Each counter steps only on clock cycles where its own count-enable input is high. Each counter drives one output pin. Three counting behaviours are provided. The first is a terminal-count flag that rises once when the loaded count runs out. The second is a periodic divider that drops its output low for one enabled cycle per period. The third is a square-wave generator that steps its count by two and toggles its output at each half period. Bus accesses complete in one cycle. Read data is registered and appears on the cycle after the read strobe.

Top module: `tri_interval_timer`

## Requirements
- R1: The slot is chosen by `addr[3:2]`: 0, 1 and 2 select the data slot of counters 0, 1 and 2, and 3 selects the command slot. `addr[1:0]` are ignored. Read data is registered on the cycle after `rd_en`. A read of the command slot returns 0x00.
- R2: In a command byte, bits 7:6 pick the counter (0..2) and bits 5:4 pick the action: 11 configures the counter and 00 snapshots it. A command byte with bits 7:6 = 11, or with bits 5:4 = 01 or 10, has no effect on any counter.
- R3: A configure command stops its counter and sets the write and read byte order back to the low byte. It also drops any pending snapshot and leaves the count value untouched. The counter counts again only once both count bytes (low, then high) have been written. Counting happens only on cycles where that counter's `cnt_en` bit is high.
- R4: Mode code 000 in bits 3:1 (terminal count) drives the output low from the configure command onward. After the high byte loads N, the output rises on the N-th enabled cycle and stays high until the counter is loaded again.
- R5: Mode code 010 or 110 (divider) keeps the output high except for one enabled cycle in every N. After the high byte is written, the output is low exactly for enabled cycles k with k mod N = N-1 (k counted from 0), for N >= 2.
- R6: Mode code 011 or 111 (square wave) keeps the internal count even and steps it by two. After load the output is high for ceil(N/2) enabled cycles, then low for floor(N/2), and this repeats with period N. The output frequency is therefore the enabled-cycle rate divided by N.
- R7: A loaded value of 0 acts as 65536.
- R8: A snapshot command copies the count without disturbing counting. The next two data reads of that counter return the snapshot's low byte and then its high byte.
- R9: A snapshot command given while a snapshot is still unread is ignored. With no snapshot pending, data reads return the live count, low byte then high byte.
- R10: Mode codes 001, 100 and 101 leave the counter unable to count. The output stays high, and a loaded value is held unchanged.
- R11: After reset all outputs are high, `rdata` is 0x00, every count is 0 and no counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 4 | Byte address of the slot |
| wdata | input | 8 | Write data byte |
| cnt_en | input | 3 | Per-counter count enable |
| rdata | output | 8 | Registered read data |
| tmr_out | output | 3 | Per-counter output pin |

## Verification
The bench sweeps every counter against every implemented mode code, including the aliased codes. It uses several small reload values, both odd and even, with continuous and gapped count enables, and it compares each output sample with a period formula. An odd reload in square-wave mode catches a design that splits the period evenly or drifts it by one. A divider that reloads a cycle early or late shows up as a low pulse in the wrong place. The snapshot sequences cover three faults: a repeated snapshot that overwrites the pending one, a configure command that leaves a stale snapshot behind, and a half-written load that starts counting. One long terminal-count run with a zero load catches a design that treats zero as an immediate terminal count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MD_TC   = 2'd0,
    MD_RATE = 2'd1,
    MD_SQ   = 2'd2,
    MD_OFF  = 2'd3
  } tmr_mode_e;

  // Bits 3:1 of a command byte; bit 3 is a don't-care for the divider and square codes.
  function automatic tmr_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'b000:         return MD_TC;
      3'b010, 3'b110: return MD_RATE;
      3'b011, 3'b111: return MD_SQ;
      default:        return MD_OFF;
    endcase
  endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] ctl_wr,
  output logic [NUM_CH-1:0] latch_cmd,
  output logic [NUM_CH-1:0] data_wr,
  output logic [NUM_CH-1:0] data_rd,
  output tmr_mode_e         mode_code,
  output logic              ctl_sel
);

  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] reg_sel;
  logic [1:0]       cw_target;
  logic [1:0]       cw_access;
  logic             unused_bits;

  assign reg_sel     = addr[ADDR_W-1:2];
  assign cw_target   = wdata[7:6];
  assign cw_access   = wdata[5:4];
  assign unused_bits = ^{addr[1:0], wdata[0]};

  always_comb begin
    ctl_wr    = '0;
    latch_cmd = '0;
    data_wr   = '0;
    data_rd   = '0;
    ctl_sel   = (reg_sel == SEL_W'(NUM_CH));
    mode_code = decode_mode(wdata[3:1]);
    for (int i = 0; i < NUM_CH; i++) begin
      data_wr[i] = wr_en && (reg_sel == SEL_W'(i));
      data_rd[i] = rd_en && (reg_sel == SEL_W'(i));
      if (wr_en && ctl_sel && (cw_target == 2'(i))) begin
        latch_cmd[i] = (cw_access == 2'b00);
        ctl_wr[i]    = (cw_access == 2'b11);
      end
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              latch_cmd,
  input  logic              data_wr,
  input  logic              data_rd,
  input  tmr_mode_e         mode_in,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  count_o,
  output tmr_mode_e         mode_o,
  output logic              armed_o,
  output logic              out_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  tmr_mode_e        mode_q;
  logic             armed_q, wr_hi_q, rd_hi_q, latched_q, out_q;
  logic [CNT_W-1:0] reload_q, count_q, snap_q;
  logic [CNT_W-1:0] full_word, start_val, hi_phase, lo_phase, nxt_count, src;
  logic             nxt_out;

  assign full_word = {wdata, reload_q[DATA_W-1:0]};
  assign start_val = (mode_q == MD_SQ) ? full_word + CNT_W'(full_word[0]) : full_word;
  assign hi_phase  = reload_q + CNT_W'(reload_q[0]);
  assign lo_phase  = reload_q - CNT_W'(reload_q[0]);

  always_comb begin
    nxt_count = count_q - ONE;
    nxt_out   = out_q;
    case (mode_q)
      MD_TC: nxt_out = out_q | (count_q == ONE);
      MD_RATE: begin
        if (count_q == ONE) nxt_count = reload_q;
        nxt_out = (nxt_count != ONE);
      end
      MD_SQ: begin
        if (count_q == TWO) begin
          nxt_out   = !out_q;
          nxt_count = out_q ? lo_phase : hi_phase;
        end else begin
          nxt_count = count_q - TWO;
        end
      end
      default: nxt_count = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MD_OFF;
      armed_q   <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
      out_q     <= 1'b1;
      reload_q  <= '0;
      count_q   <= '0;
      snap_q    <= '0;
    end else if (ctl_wr) begin
      mode_q    <= mode_in;
      armed_q   <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
      out_q     <= (mode_in != MD_TC);
    end else begin
      if (data_wr) begin
        if (!wr_hi_q) begin
          reload_q[DATA_W-1:0] <= wdata;
          wr_hi_q              <= 1'b1;
        end else begin
          reload_q[CNT_W-1:DATA_W] <= wdata;
          wr_hi_q                  <= 1'b0;
          armed_q                  <= (mode_q != MD_OFF);
          count_q                  <= start_val;
          out_q                    <= (mode_q != MD_TC);
        end
      end else if (tick && armed_q) begin
        count_q <= nxt_count;
        out_q   <= nxt_out;
      end
      if (latch_cmd && !latched_q) begin
        snap_q    <= count_q;
        latched_q <= 1'b1;
        rd_hi_q   <= 1'b0;
      end else if (data_rd) begin
        if (rd_hi_q) begin
          rd_hi_q   <= 1'b0;
          latched_q <= 1'b0;
        end else begin
          rd_hi_q   <= 1'b1;
        end
      end
    end
  end

  assign src     = latched_q ? snap_q : count_q;
  assign rd_byte = rd_hi_q ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
  assign count_o = count_q;
  assign mode_o  = mode_q;
  assign armed_o = armed_q;
  assign out_o   = out_q;

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] cnt_en,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] tmr_out
);

  localparam int CNT_W = 2 * DATA_W;
  localparam int SEL_W = ADDR_W - 2;

  logic [NUM_CH-1:0]       ctl_wr, latch_cmd, data_wr, data_rd;
  tmr_mode_e               mode_code;
  logic                    ctl_sel;
  logic [DATA_W-1:0]       rd_bytes [NUM_CH];
  logic [DATA_W-1:0]       rd_mux;
  logic [CNT_W*NUM_CH-1:0] cnt_all;
  logic [2*NUM_CH-1:0]     mode_all;
  logic [NUM_CH-1:0]       armed_all;

  tmr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .ctl_wr(ctl_wr), .latch_cmd(latch_cmd), .data_wr(data_wr), .data_rd(data_rd),
    .mode_code(mode_code), .ctl_sel(ctl_sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_mode_e ch_mode;
    tmr_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst),
      .ctl_wr(ctl_wr[g]), .latch_cmd(latch_cmd[g]),
      .data_wr(data_wr[g]), .data_rd(data_rd[g]),
      .mode_in(mode_code), .wdata(wdata), .tick(cnt_en[g]),
      .rd_byte(rd_bytes[g]), .count_o(cnt_all[g*CNT_W +: CNT_W]),
      .mode_o(ch_mode), .armed_o(armed_all[g]), .out_o(tmr_out[g])
    );
    assign mode_all[2*g +: 2] = ch_mode;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr[ADDR_W-1:2] == SEL_W'(i)) rd_mux = rd_bytes[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= ctl_sel ? '0 : rd_mux;
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 2 * DATA_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic                    rd_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [DATA_W-1:0]       wdata,
  input logic [DATA_W-1:0]       rdata,
  input logic [NUM_CH-1:0]       tmr_out,
  input logic [CNT_W*NUM_CH-1:0] cnt_all,
  input logic [2*NUM_CH-1:0]     mode_all,
  input logic [NUM_CH-1:0]       armed_all
);

  localparam int SEL_W = ADDR_W - 2;

  // R1: the command slot reads back as zero
  a_r1_ctl_read_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en && (addr[ADDR_W-1:2] == SEL_W'(NUM_CH)) |=> rdata == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R4: configuring terminal-count mode pulls the pin low
    a_r4_tc_low_after_ctl: assert property (@(posedge clk) disable iff (rst)
      wr_en && (addr[ADDR_W-1:2] == SEL_W'(NUM_CH)) && (wdata[7:6] == 2'(i)) &&
      (wdata[5:4] == 2'b11) && (wdata[3:1] == 3'b000) |=> !tmr_out[i]);

    // R5: in divider mode the pin is low only while the count sits at one
    a_r5_rate_low_at_one: assert property (@(posedge clk) disable iff (rst)
      (mode_all[2*i +: 2] == MD_RATE) && !tmr_out[i] |-> cnt_all[i*CNT_W +: CNT_W] == CNT_W'(1));

    // R6: a running square-wave count is always even
    a_r6_sq_count_even: assert property (@(posedge clk) disable iff (rst)
      (mode_all[2*i +: 2] == MD_SQ) && armed_all[i] |-> !cnt_all[i*CNT_W]);

    // R3: a stopped counter holds its count while nothing is written
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
      !armed_all[i] && !wr_en |=> $stable(cnt_all[i*CNT_W +: CNT_W]));

    // R10: unsupported modes keep the pin high
    a_r10_off_out_high: assert property (@(posedge clk) disable iff (rst)
      (mode_all[2*i +: 2] == MD_OFF) |-> tmr_out[i]);
  end

endmodule

bind tri_interval_timer tmr_checker #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out), .cnt_all(cnt_all),
  .mode_all(mode_all), .armed_all(armed_all)
);

// File: tb/sim_tri_interval_timer.sv
module sim_tri_interval_timer;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] CTL = 4'hC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [2:0] cnt_en = '0;
  logic [7:0] rdata;
  logic [2:0] tmr_out;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_interval_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_en(cnt_en), .rdata(rdata), .tmr_out(tmr_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd16(input int ch, output int v);
    logic [7:0] lo, hi;
    rd(4'(ch*4), lo);
    rd(4'(ch*4), hi);
    v = {16'd0, hi, lo};
  endtask

  task automatic load(input int ch, input int code, input int n);
    wr(CTL, {2'(ch), 2'b11, 3'(code), 1'b0});
    wr(4'(ch*4), 8'(n));
    wr(4'(ch*4), 8'(n >> 8));
  endtask

  task automatic ticks(input int ch, input int n);
    cnt_en[ch] = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en[ch] = 1'b0;
  endtask

  // expected pin after k enabled cycles; kind 0 = terminal count, 1 = divider, 2 = square
  function automatic int exp_out(input int kind, input int n, input int k);
    int nn = (n == 0) ? 65536 : n;
    case (kind)
      0:       return (k >= nn) ? 1 : 0;
      1:       return ((k % nn) != nn - 1) ? 1 : 0;
      default: return ((k % nn) < (nn + 1) / 2) ? 1 : 0;
    endcase
  endfunction

  function automatic int kind_of(input int code);
    if (code == 0) return 0;
    if (code == 2 || code == 6) return 1;
    return 2;
  endfunction

  task automatic run_mode(input int ch, input int code, input int n, input bit gap);
    int k = 0, cyc = 0, bad = 0, last_act = 0, last_exp = 0;
    int kind = kind_of(code);
    string req = (kind == 0) ? "R4" : (kind == 1) ? "R5" : "R6";
    load(ch, code, n);
    while (k < 2 * n + 4) begin
      if (int'(tmr_out[ch]) != exp_out(kind, n, k)) begin
        bad++; last_act = tmr_out[ch]; last_exp = exp_out(kind, n, k);
      end
      cnt_en[ch] = gap ? ((cyc % 3) != 0) : 1'b1;
      if (cnt_en[ch]) k++;
      cyc++;
      @(negedge clk);
    end
    cnt_en[ch] = 1'b0;
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s ch%0d code%0d N=%0d gap=%0d mismatches=%0d actual=%0d expected=%0d",
               req, ch, code, n, gap, bad, last_act, last_exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    logic [7:0] b;
    int codes [5] = '{0, 2, 3, 6, 7};
    int ns [6] = '{2, 3, 4, 5, 8, 11};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 out", tmr_out, 7);
    chk("R11 rdata", rdata, 0);
    rd16(0, v); chk("R11 count", v, 0);
    rd(CTL, b); chk("R1 ctl read", b, 0);

    // R4 R5 R6 sweep over channels, codes, reloads and enable patterns
    foreach (codes[c])
      for (int ch = 0; ch < 3; ch++)
        foreach (ns[j]) begin
          run_mode(ch, codes[c], ns[j], 1'b0);
          run_mode(ch, codes[c], ns[j], 1'b1);
        end

    // R1 R5 R6 two channels concurrently, independent slots
    begin
      int bad0 = 0, bad2 = 0;
      load(0, 2, 5);
      load(2, 3, 7);
      for (int k = 0; k < 30; k++) begin
        if (int'(tmr_out[0]) != exp_out(1, 5, k)) bad0++;
        if (int'(tmr_out[2]) != exp_out(2, 7, k)) bad2++;
        cnt_en = 3'b101;
        @(negedge clk);
      end
      cnt_en = '0;
      chk("R5 concurrent ch0 mismatches", bad0, 0);
      chk("R6 concurrent ch2 mismatches", bad2, 0);
      chk("R1 idle ch1 out", tmr_out[1], 1);
    end

    // R8 R9 snapshot behaviour on counter 1
    load(1, 0, 1000);
    ticks(1, 37);
    wr(CTL, 8'h40);
    ticks(1, 10);
    rd16(1, v); chk("R8 snapshot", v, 963);
    rd16(1, v); chk("R9 live read", v, 953);
    wr(CTL, 8'h40);
    ticks(1, 5);
    wr(CTL, 8'h40);
    ticks(1, 5);
    rd16(1, v); chk("R9 second snapshot ignored", v, 953);
    rd16(1, v); chk("R9 live after snapshot", v, 943);
    // R3 configure drops a pending snapshot and keeps the count
    wr(CTL, 8'h40);
    ticks(1, 3);
    wr(CTL, 8'h70);
    rd16(1, v); chk("R3 snapshot cleared", v, 940);

    // R2 ignored command bytes on a running counter 0
    load(0, 0, 500);
    ticks(0, 20);
    wr(CTL, 8'h10);
    wr(CTL, 8'h20);
    wr(CTL, 8'hF0);
    rd16(0, v); chk("R2 ignored commands keep count", v, 480);
    ticks(0, 10);
    rd16(0, v); chk("R2 still counting", v, 470);
    chk("R2 out unchanged", tmr_out[0], 0);

    // R3 byte order and stop until both bytes on counter 2
    load(2, 0, 100);
    ticks(2, 10);
    wr(CTL, 8'hB0);
    wr(4'h8, 8'h55);
    ticks(2, 5);
    rd16(2, v); chk("R3 stopped after low byte", v, 90);
    wr(CTL, 8'hB0);
    wr(4'h8, 8'h34);
    wr(4'h9, 8'h12);
    rd16(2, v); chk("R3 low byte first after reconfigure", v, 16'h1234);
    ticks(2, 4);
    rd16(2, v); chk("R3 counting resumed", v, 16'h1230);

    // R10 unsupported codes hold the count and keep the pin high
    foreach (ns[j]) begin
      int code = (j % 3 == 0) ? 1 : (j % 3 == 1) ? 4 : 5;
      if (j < 3) begin
        load(0, code, 10);
        ticks(0, 20);
        rd16(0, v); chk("R10 count held", v, 10);
        chk("R10 out high", tmr_out[0], 1);
      end
    end

    // R7 zero load counts 65536 in terminal-count mode
    load(1, 0, 0);
    cnt_en[1] = 1'b1;
    repeat (65535) @(negedge clk);
    chk("R7 not yet terminal", tmr_out[1], 0);
    @(negedge clk);
    cnt_en[1] = 1'b0;
    chk("R7 terminal at 65536", tmr_out[1], 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule